// File: doc/BRIEF.md
# I2C Register Slave with Auto-Incrementing Pointer

This block is an I2C target that gives a host byte-wide access to a small register file. It oversamples the two bus lines on the system clock, finds START, repeated START and STOP on the resynchronised samples, and answers to one of two fixed 7-bit addresses. A strap input picks which address is active. The first byte the host writes after a write-direction address loads an internal register pointer. Each further written byte goes to the pointed register, and the pointer then steps by one.

A read uses the same pointer. The host writes the pointer byte, issues a repeated START with the read bit set, and clocks out bytes. Each byte comes from the pointed register, and the pointer steps after every byte. The slave stops sending when the host answers a byte with NACK. The pointer keeps its value between transfers. A later read that goes straight to a read-direction address therefore continues where the last access ended.

The register file sits outside the block on a plain port: address, write data, a one-cycle write strobe, and combinational read data. SDA is only ever pulled low through an open-drain enable.

Top module: `i2c_regslave`

## Requirements
- R1: With `addr_sel` low the slave answers to address 0x29 (0101001b); with `addr_sel` high it answers to 0x56 (1010110b). The address byte carries the address in bits 7:1 and R/nW in bit 0. The slave acknowledges a matching address byte by asserting `sda_pull` through the ninth SCL pulse, so the bus reads 0 there.
- R2: After an address byte that does not match, the slave never pulls SDA and makes no register write until the next START. This holds for every byte that follows.
- R3: A START or repeated START, even in the middle of a byte, restarts the address phase. A STOP returns the slave to idle, and bytes clocked after that STOP without a new START are ignored.
- R4: In a write transfer, the first data byte loads the pointer from its low 5 bits; bits 7:5 are ignored. Each later data byte produces exactly one single-cycle `reg_we` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increases by one.
- R5: Every byte received in an addressed write transfer, the pointer byte included, is acknowledged.
- R6: After a repeated START with a matching read address, bytes are shifted out MSB first, starting from the register at the pointer. The pointer increases by one for each byte sent.
- R7: The slave keeps sending while the host acknowledges. After a NACK it releases SDA and stays silent. The pointer is kept, so a read that starts directly with a read address continues at the next register.
- R8: The pointer wraps from 31 to 0 on both writes and reads.
- R9: SDA is driven only as an open-drain enable. `sda_pull` stays low while the host sends address or data bits, and it never changes while synchronised SCL is high.
- R10: After reset `sda_pull` and `reg_we` are 0 and the pointer (`reg_addr`) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus (wired-AND value) |
| addr_sel | input | 1 | Address strap: 0 selects 0x29, 1 selects 0x56 |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr | output | 5 | Register pointer / register file address |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register file at `reg_addr` |

## Verification
A pointer that is off by one or fails to wrap shows up at the write port as a wrong `reg_addr` on the very next strobe. On a read it shows up as a wrong byte on the first data bit after the address acknowledge. A wrong protocol state, such as a missed START, STOP or NACK, shows up within one bit time as SDA pulled low in a slot where the host owns the line, or as an acknowledge missing on the ninth clock. A write strobe that appears where none is expected is flagged on the clock cycle in which it occurs.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } i2cs_state_e;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   // Reset to all ones: an idle I2C bus is high on both lines.
   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[g] <= '1;
               else        chain[g] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[g] <= '1;
               else        chain[g] <= chain[g-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_busdet.sv
module i2cs_busdet (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   // SDA may only move while SCL is held high for a START or STOP.
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
   import i2cs_pkg::*;
#(
   parameter int          ADDR_W  = 7,
   parameter int          DATA_W  = 8,
   parameter int          PTR_W   = 5,
   parameter logic [6:0]  DEV_LO  = 7'b0101001,
   parameter logic [6:0]  DEV_HI  = 7'b1010110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_sel,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [DATA_W-1:0] rdata,
   output logic [PTR_W-1:0]  ptr,
   output logic [DATA_W-1:0] wdata,
   output logic              we,
   output logic              sda_pull,
   output i2cs_state_e       state
);
   localparam int              CNT_W   = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

   logic [CNT_W-1:0]  bitcnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] txreg;
   logic              rnw;
   logic              host_ack;
   logic [ADDR_W-1:0] dev_addr;
   logic [PTR_W-1:0]  ptr_load;

   assign dev_addr = addr_sel ? DEV_HI : DEV_LO;

   // Pointer load: take the whole byte when the pointer is byte-wide,
   // otherwise keep only its low bits.
   generate
      if (PTR_W == DATA_W) begin : g_ptr_full
         assign ptr_load = shreg;
      end else begin : g_ptr_trunc
         assign ptr_load = shreg[PTR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         txreg    <= '0;
         ptr      <= '0;
         wdata    <= '0;
         we       <= 1'b0;
         sda_pull <= 1'b0;
         rnw      <= 1'b0;
         host_ack <= 1'b0;
      end else begin
         we <= 1'b0;
         if (stop_det) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else if (start_det) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_PTR, ST_WR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[DATA_W-2:0], sda_s};
                     bitcnt <= bitcnt + CNT_ONE;
                  end else if (scl_fall && bitcnt == CNT_FULL) begin
                     bitcnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[DATA_W-1:DATA_W-ADDR_W] == dev_addr) begin
                           rnw      <= shreg[0];
                           sda_pull <= 1'b1;
                           state    <= ST_ADDR_ACK;
                        end else begin
                           state    <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        ptr      <= ptr_load;
                        sda_pull <= 1'b1;
                        state    <= ST_PTR_ACK;
                     end else begin
                        wdata    <= shreg;
                        we       <= 1'b1;
                        sda_pull <= 1'b1;
                        state    <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rnw) begin
                        txreg    <= rdata;
                        sda_pull <= ~rdata[DATA_W-1];
                        ptr      <= ptr + PTR_ONE;
                        bitcnt   <= '0;
                        state    <= ST_RD;
                     end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_PTR;
                     end
                  end
               end
               ST_PTR_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     state    <= ST_WR;
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     ptr      <= ptr + PTR_ONE;
                     state    <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (bitcnt == CNT_LAST) begin
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                        state    <= ST_RD_ACK;
                     end else begin
                        sda_pull <= ~txreg[DATA_W-2];
                        txreg    <= {txreg[DATA_W-2:0], 1'b0};
                        bitcnt   <= bitcnt + CNT_ONE;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        txreg    <= rdata;
                        sda_pull <= ~rdata[DATA_W-1];
                        ptr      <= ptr + PTR_ONE;
                        state    <= ST_RD;
                     end else begin
                        state    <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  sda_pull <= 1'b0;
               end
            endcase
         end
      end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
   import i2cs_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         ADDR_W      = 7,
   parameter int         DATA_W      = 8,
   parameter int         PTR_W       = 5,
   parameter logic [6:0] DEV_LO      = 7'b0101001,
   parameter logic [6:0] DEV_HI      = 7'b1010110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_sel,
   output logic              sda_pull,
   output logic [PTR_W-1:0]  reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W != 8 || ADDR_W != 7) begin : g_bad_width
         $error("I2C bytes are 8 bits with a 7-bit address");
      end
      if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
         $error("PTR_W must lie between 1 and DATA_W");
      end
      if (DEV_LO == DEV_HI) begin : g_bad_dev
         $error("the two device addresses must differ");
      end
   endgenerate

   logic [1:0]  bus_s;
   logic        scl_s, sda_s;
   logic        scl_rise, scl_fall, start_det, stop_det;
   i2cs_state_e fsm_state;

   i2cs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   i2cs_busdet u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cs_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PTR_W  (PTR_W),
      .DEV_LO (DEV_LO),
      .DEV_HI (DEV_HI)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_sel  (addr_sel),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .rdata     (reg_rdata),
      .ptr       (reg_addr),
      .wdata     (reg_wdata),
      .we        (reg_we),
      .sda_pull  (sda_pull),
      .state     (fsm_state)
   );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
   import i2cs_pkg::*;
#(
   parameter int PTR_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input i2cs_state_e      state,
   input logic             sda_pull,
   input logic             reg_we,
   input logic [PTR_W-1:0] reg_addr
);
   // R4: a write strobe lasts a single cycle
   p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R5: every register write coincides with the acknowledge pull
   p_ack_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> sda_pull);

   // R4: leaving the write acknowledge steps the pointer by one
   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_WR_ACK && state == ST_WR)
         |-> reg_addr == $past(reg_addr) + PTR_W'(1));

   // R2: an idle slave leaves SDA alone
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull);

   // R9: the pull never moves while SCL is high
   p_hold_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_pull));

   // R6: no register write while sending read data
   p_rd_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD || state == ST_RD_ACK) |-> !reg_we);
endmodule

bind i2c_regslave i2cs_chk #(.PTR_W(PTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .state    (fsm_state),
   .sda_pull (sda_pull),
   .reg_we   (reg_we),
   .reg_addr (reg_addr)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_sel = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_pull;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       reg_we;
   logic       sda_bus;

   always #5 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull;

   i2c_regslave uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .addr_sel  (addr_sel),
      .sda_pull  (sda_pull),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   // register file attached to the slave
   logic [7:0] mem [32];
   assign reg_rdata = mem[reg_addr];
   always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

   // behavioural reference
   logic [7:0]  mdl_mem [32];
   int          mdl_ptr = 0;
   logic [12:0] exp_wr [$];
   int          checks = 0;
   int          fails = 0;
   bit          quiet = 0;
   int          qviol = 0;
   bit          done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison of the write port against the expected queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (reg_we) begin
            if (exp_wr.size() == 0) begin
               chk(1'b0, "R4 unexpected register write", int'({reg_addr, reg_wdata}), 0);
            end else begin
               logic [12:0] e;
               e = exp_wr.pop_front();
               chk({reg_addr, reg_wdata} == e, "R4 write port address/data",
                   int'({reg_addr, reg_wdata}), int'(e));
            end
         end
         if (quiet && sda_pull) qviol++;
      end
   end

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bitx(input bit b, output bit r, output bit oe);
      m_sda = b;
      wait_q();
      m_scl = 1'b1;
      repeat (Q / 2) @(negedge clk);
      r  = sda_bus;
      oe = sda_pull;
      repeat (Q / 2) @(negedge clk);
      m_scl = 1'b0;
      wait_q();
   endtask

   task automatic start_c();
      m_sda = 1'b1; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b0; wait_q();
   endtask

   task automatic stop_c();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b1; wait_q();
      wait_q();
   endtask

   task automatic wbyte(input logic [7:0] d, output bit ack);
      bit r, oe;
      bit oe_any = 0;
      for (int i = 7; i >= 0; i--) begin
         bitx(d[i], r, oe);
         oe_any |= oe;
      end
      chk(!oe_any, "R9 slave pulled SDA during host bits", int'(oe_any), 0);
      bitx(1'b1, r, oe);
      ack = ~r;
   endtask

   task automatic rbyte(input bit host_ack, output logic [7:0] d);
      bit r, oe;
      for (int i = 7; i >= 0; i--) begin
         bitx(1'b1, r, oe);
         d[i] = r;
      end
      bitx(~host_ack, r, oe);
   endtask

   task automatic do_write(input logic [6:0] dev, input logic [7:0] p,
                           input int n, input logic [7:0] base);
      bit ack;
      start_c();
      wbyte({dev, 1'b0}, ack);
      chk(ack, "R1 matching write address acknowledged", int'(ack), 1);
      wbyte(p, ack);
      chk(ack, "R5 pointer byte acknowledged", int'(ack), 1);
      mdl_ptr = int'(p) % 32;
      for (int k = 0; k < n; k++) begin
         logic [7:0] d;
         d = base + 8'(k * 13);
         exp_wr.push_back({5'(mdl_ptr), d});
         mdl_mem[mdl_ptr] = d;
         wbyte(d, ack);
         chk(ack, "R5 data byte acknowledged", int'(ack), 1);
         mdl_ptr = (mdl_ptr + 1) % 32;
      end
      stop_c();
      chk(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);
   endtask

   task automatic do_read(input logic [6:0] dev, input bit set_ptr,
                          input logic [7:0] p, input int n, input string req);
      bit ack, r, oe;
      logic [7:0] d;
      start_c();
      if (set_ptr) begin
         wbyte({dev, 1'b0}, ack);
         chk(ack, "R1 address acknowledged before read", int'(ack), 1);
         wbyte(p, ack);
         chk(ack, "R5 read pointer byte acknowledged", int'(ack), 1);
         mdl_ptr = int'(p) % 32;
         start_c();
      end
      wbyte({dev, 1'b1}, ack);
      chk(ack, "R6 read address acknowledged", int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         rbyte(k < n - 1, d);
         chk(d == mdl_mem[mdl_ptr], req, int'(d), int'(mdl_mem[mdl_ptr]));
         mdl_ptr = (mdl_ptr + 1) % 32;
      end
      quiet = 1; qviol = 0;
      bitx(1'b1, r, oe);
      bitx(1'b1, r, oe);
      quiet = 0;
      chk(qviol == 0, "R7 SDA released after NACK", qviol, 0);
      stop_c();
   endtask

   task automatic do_foreign(input logic [6:0] dev, input string req);
      bit ack;
      quiet = 1; qviol = 0;
      start_c();
      wbyte({dev, 1'b0}, ack);
      chk(!ack, req, int'(ack), 0);
      wbyte(8'h05, ack);
      wbyte(8'hEE, ack);
      wbyte(8'h11, ack);
      stop_c();
      quiet = 0;
      chk(qviol == 0, "R2 silent after foreign address", qviol, 0);
   endtask

   initial begin
      bit ack, r, oe;
      for (int i = 0; i < 32; i++) begin
         mem[i]     = 8'(i * 37 + 11);
         mdl_mem[i] = 8'(i * 37 + 11);
      end
      repeat (4) @(negedge clk);
      chk(sda_pull == 1'b0, "R10 reset sda_pull", int'(sda_pull), 0);
      chk(reg_we == 1'b0, "R10 reset reg_we", int'(reg_we), 0);
      chk(reg_addr == 5'd0, "R10 reset pointer", int'(reg_addr), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 R4 R5: strap low, burst write from 3
      do_write(7'h29, 8'h03, 3, 8'hA5);
      // R6: pointed read of three bytes
      do_read(7'h29, 1'b1, 8'h04, 3, "R6 read data from pointer");
      // R7: direct read continues after the previous pointer
      do_read(7'h29, 1'b0, 8'h00, 2, "R7 read continues from kept pointer");
      // R2: other address ignored with strap low
      do_foreign(7'h56, "R2 foreign address not acknowledged");

      // R1: strap high; upper pointer bits dropped (R4)
      addr_sel = 1'b1;
      repeat (8) @(negedge clk);
      do_write(7'h56, 8'hE2, 2, 8'h3C);
      do_read(7'h56, 1'b1, 8'h02, 2, "R4 pointer takes low five bits");
      do_foreign(7'h29, "R1 low-strap address refused when strap high");

      // R8: wrap on write and read
      do_write(7'h56, 8'h1E, 3, 8'h70);
      do_read(7'h56, 1'b1, 8'h1F, 3, "R8 read pointer wraps");

      // R3: repeated START in the middle of a data byte
      start_c();
      wbyte({7'h56, 1'b0}, ack);
      wbyte(8'h10, ack);
      for (int i = 0; i < 4; i++) bitx(1'b0, r, oe);
      start_c();
      wbyte({7'h56, 1'b0}, ack);
      chk(ack, "R3 address phase restarted by mid-byte START", int'(ack), 1);
      wbyte(8'h11, ack);
      exp_wr.push_back({5'h11, 8'h9D});
      mdl_mem[5'h11] = 8'h9D;
      wbyte(8'h9D, ack);
      stop_c();
      chk(exp_wr.size() == 0, "R3 write after restart landed", exp_wr.size(), 0);

      // R3: after STOP, bytes without START are ignored
      quiet = 1; qviol = 0;
      wbyte({7'h56, 1'b0}, ack);
      wbyte(8'h00, ack);
      wbyte(8'h42, ack);
      quiet = 0;
      chk(qviol == 0, "R3 no response after STOP", qviol, 0);
      m_sda = 1'b1; m_scl = 1'b1;
      wait_q();
      do_read(7'h56, 1'b1, 8'h11, 1, "R3 register file unchanged by ignored bytes");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule